// File: doc/BRIEF.md
# Prioritised NMI Source Controller

This block collects five non-maskable interrupt causes into one byte of pending flags and raises a single request line towards the CPU. The causes are the external NMI pin, the oscillation-stop detector, the watchdog (underflow or refresh error), and two voltage monitors. Each cause arrives as a one-cycle event pulse from its own detector. The pulse latches a pending flag whether or not the cause is enabled. Only enabled causes drive the request.

Software reaches three byte registers over a simple byte-wide bus: pending flags at offset 0, enables at offset 1 and a write-one-to-clear register at offset 2. The three registers share one sparse bit map: pin on bit 0, oscillation stop on bit 1, watchdog on bit 3, and the two voltage monitors on bits 4 and 5. Bit 2 and bits 6 and 7 are not used.

A handler reads an encoded index of the highest-priority pending cause. It services that cause, clears the flag, and repeats until the index reads "none". An enable, once set, stays set until reset.

Top module: `nmi_source_ctrl`

## Requirements
- R1: After reset the pending register and the enable register read 0x00, the request output is 0, and the index output is 5.
- R2: An event pulse on source input k (0 pin, 1 oscillation stop, 2 watchdog, 3 voltage monitor 1, 4 voltage monitor 2) sets pending bit 0, 1, 3, 4 or 5 respectively at the next clock edge. This happens even when that source is not enabled.
- R3: Bits 2, 6 and 7 of the pending and enable registers always read 0. This holds even after 0xFF is written to the enable register.
- R4: Writing offset 1 sets every enable bit whose written value is 1. An enable bit never returns to 0 before reset, so writing 0 has no effect.
- R5: Writing offset 2 clears every pending bit whose written value is 1. Bits written with 0 keep their value, and offset 2 always reads 0x00.
- R6: If an event for a source and a clear of the same bit occur in the same cycle, the pending bit is 1 after that edge.
- R7: The request output is registered. It is 1 in exactly the cycles in which the pending register ANDed with the enable register is non-zero. It rises at the same edge that latches the enabled event.
- R8: The index output gives the highest-priority pending source, whether enabled or not. Priority runs pin (0), oscillation stop (1), watchdog (2), voltage monitor 1 (3), voltage monitor 2 (4), and the index reads 5 when nothing is pending.
- R9: Writes to offset 0 and offset 3 change no state, and offset 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register byte offset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| src_event | input | 5 | One-cycle event pulses, index 0 pin to 4 voltage monitor 2 |
| nmi_req | output | 1 | Registered non-maskable request to the CPU |
| pend_index | output | 3 | Highest-priority pending source, 5 when none |

## Verification
The bench builds the block with its default parameters: five sources, an eight-bit data path and a two-bit offset. With these values every used bit, each unused bit and the spare offset 3 can be reached from the bus. The handler loop steps the index through every priority level down to "none". Same-cycle event and clear collisions, sticky enables and the request staying low while causes are pending but disabled are each driven directly.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  localparam int OFS_PENDING = 0;
  localparam int OFS_ENABLE  = 1;
  localparam int OFS_CLEAR   = 2;

  typedef enum logic [1:0] {
    RD_PENDING = 2'd0,
    RD_ENABLE  = 2'd1,
    RD_ZERO    = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   enableWr;
    logic   clearWr;
    rdSel_e rdSel;
  } regStrobe_t;

  // Source index to register bit: bit 2 is skipped.
  function automatic int srcBitPos(input int idx);
    return (idx < 2) ? idx : idx + 1;
  endfunction

  function automatic logic [31:0] usedMaskOf(input int numSrc);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < numSrc; i++) m[srcBitPos(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/nmi_reg_ctrl.sv
module nmi_reg_ctrl
  import nmi_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output regStrobe_t        strobe
);

  always_comb begin
    strobe.enableWr = regWr && (regAddr == ADDR_W'(OFS_ENABLE));
    strobe.clearWr  = regWr && (regAddr == ADDR_W'(OFS_CLEAR));
    if (regAddr == ADDR_W'(OFS_PENDING))     strobe.rdSel = RD_PENDING;
    else if (regAddr == ADDR_W'(OFS_ENABLE)) strobe.rdSel = RD_ENABLE;
    else                                     strobe.rdSel = RD_ZERO;
  end

  // R9: a single offset is decoded per access
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.enableWr, strobe.clearWr}));

  // R9: writes outside offsets 1 and 2 produce no strobe
  p_no_stray_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && regAddr != ADDR_W'(OFS_ENABLE) && regAddr != ADDR_W'(OFS_CLEAR))
      |-> !(strobe.enableWr || strobe.clearWr));

endmodule

// File: rtl/nmi_datapath.sv
module nmi_datapath
  import nmi_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic [NUM_SRC-1:0] srcEvent,
  output logic [DATA_W-1:0]  regRdata,
  output logic               nmiReq,
  output logic [IDX_W-1:0]   pendIdx
);

  localparam logic [DATA_W-1:0] USED_MASK = DATA_W'(usedMaskOf(NUM_SRC));

  logic [DATA_W-1:0] pendQ, pendD, enableQ, enableD, evtMap, clrMap, setMap;
  logic              nmiQ;

  // Map event pulses onto the sparse bit layout.
  always_comb begin
    evtMap = '0;
    for (int i = 0; i < NUM_SRC; i++) evtMap[srcBitPos(i)] = srcEvent[i];
  end

  assign clrMap = strobe.clearWr  ? (regWdata & USED_MASK) : '0;
  assign setMap = strobe.enableWr ? (regWdata & USED_MASK) : '0;

  // An event has priority over a clear of the same bit.
  assign pendD   = ((pendQ & ~clrMap) | evtMap) & USED_MASK;
  assign enableD = enableQ | setMap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendQ   <= '0;
      enableQ <= '0;
      nmiQ    <= 1'b0;
    end else begin
      pendQ   <= pendD;
      enableQ <= enableD;
      nmiQ    <= |(pendD & enableD);
    end
  end

  // Fixed priority: lowest source index wins.
  always_comb begin
    pendIdx = IDX_W'(NUM_SRC);
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[srcBitPos(i)]) pendIdx = IDX_W'(i);
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_PENDING: regRdata = pendQ;
      RD_ENABLE:  regRdata = enableQ;
      default:    regRdata = '0;
    endcase
  end

  assign nmiReq = nmiQ;

  // R7: request matches the enabled pending set
  p_req_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmiReq == |(pendQ & enableQ));

  // R4: enables never drop
  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~enableQ & $past(enableQ)) == '0));

  // R3: unused positions stay zero
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendQ | enableQ) & ~USED_MASK) == '0);

  // R8: index never beyond "none"
  p_index_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pendIdx <= IDX_W'(NUM_SRC));

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src_chk
    localparam int BP = srcBitPos(g);
    // R2 and R6: an event always leaves its bit set
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      srcEvent[g] |=> pendQ[BP]);
    // R5: clear without a competing event drops the bit
    p_clear_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.clearWr && regWdata[BP] && !srcEvent[g]) |=> !pendQ[BP]);
  end

endmodule

// File: rtl/nmi_source_ctrl.sv
module nmi_source_ctrl #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic [NUM_SRC-1:0]           src_event,
  output logic                         nmi_req,
  output logic [$clog2(NUM_SRC+1)-1:0] pend_index
);

  nmi_pkg::regStrobe_t strobe;

  nmi_reg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .regAddr (reg_addr),
    .regWr   (reg_wr),
    .strobe  (strobe)
  );

  nmi_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .regWdata (reg_wdata),
    .srcEvent (src_event),
    .regRdata (reg_rdata),
    .nmiReq   (nmi_req),
    .pendIdx  (pend_index)
  );

endmodule

// File: tb/nmi_source_ctrl_tb_top.sv
module nmi_source_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [4:0] src_event = '0;
  logic       nmi_req;
  logic [2:0] pend_index;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_source_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_event(src_event),
    .nmi_req(nmi_req), .pend_index(pend_index)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Drive one bus write (and optional events) for one cycle.
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [4:0] ev);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; src_event = ev;
    @(negedge clk);
    reg_wr = 1'b0; src_event = '0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [4:0] ev);
    @(negedge clk);
    src_event = ev;
    @(negedge clk);
    src_event = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); chk("R1 pending", d, 8'h00);
    rd(2'd1, d); chk("R1 enable", d, 8'h00);
    chk("R1 nmi_req", nmi_req, 0);
    chk("R1 index", pend_index, 5);
  endtask

  task automatic t_events_disabled;
    logic [7:0] d;
    pulse(5'b00100);
    rd(2'd0, d); chk("R2 watchdog to bit3", d, 8'h08);
    chk("R8 index watchdog", pend_index, 2);
    pulse(5'b11011);
    rd(2'd0, d); chk("R2 all sources map", d, 8'h3B);
    chk("R7 no request while disabled", nmi_req, 0);
    chk("R8 index pin", pend_index, 0);
  endtask

  task automatic t_clear_walk;
    logic [7:0] d;
    wr(2'd2, 8'h00, '0);
    rd(2'd0, d); chk("R5 clear zero no effect", d, 8'h3B);
    rd(2'd2, d); chk("R5 clear reads zero", d, 8'h00);
    wr(2'd2, 8'h01, '0); chk("R8 index osc", pend_index, 1);
    wr(2'd2, 8'h02, '0); chk("R8 index watchdog", pend_index, 2);
    wr(2'd2, 8'h08, '0); chk("R8 index vm1", pend_index, 3);
    wr(2'd2, 8'h10, '0); chk("R8 index vm2", pend_index, 4);
    wr(2'd2, 8'h20, '0); chk("R8 index none", pend_index, 5);
    rd(2'd0, d); chk("R5 all cleared", d, 8'h00);
  endtask

  task automatic t_bus_misc;
    logic [7:0] d;
    pulse(5'b00001);
    wr(2'd0, 8'h00, '0);
    rd(2'd0, d); chk("R9 pending write ignored", d, 8'h01);
    wr(2'd3, 8'hFF, '0);
    rd(2'd1, d); chk("R9 offset3 write ignored", d, 8'h00);
    rd(2'd3, d); chk("R9 offset3 reads zero", d, 8'h00);
    wr(2'd2, 8'hFF, '0);
    rd(2'd0, d); chk("R5 clear all", d, 8'h00);
  endtask

  task automatic t_enable_sticky;
    logic [7:0] d;
    wr(2'd1, 8'hFF, '0);
    rd(2'd1, d); chk("R3 unused enable bits zero", d, 8'h3B);
    wr(2'd1, 8'h00, '0);
    rd(2'd1, d); chk("R4 enable sticky", d, 8'h3B);
    chk("R7 no request with nothing pending", nmi_req, 0);
  endtask

  task automatic t_request;
    logic [7:0] d;
    @(negedge clk); src_event = 5'b10000;
    @(negedge clk); src_event = '0;
    chk("R7 request rises with event", nmi_req, 1);
    rd(2'd0, d); chk("R3 pending unused zero", d, 8'h20);
    repeat (3) @(negedge clk);
    chk("R7 request holds", nmi_req, 1);
    wr(2'd2, 8'h20, '0);
    chk("R7 request drops on clear", nmi_req, 0);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    wr(2'd2, 8'h02, 5'b00010);
    rd(2'd0, d); chk("R6 event beats clear", d, 8'h02);
    chk("R7 request on collision", nmi_req, 1);
    wr(2'd2, 8'h02, '0);
    rd(2'd0, d); chk("R5 cleared after collision", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events_disabled();
    t_clear_walk();
    t_bus_misc();
    t_enable_sticky();
    t_request();
    t_collision();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule